// File: doc/BRIEF.md
# Inbound PCI Address Window Translator

This block decides whether an incoming PCI memory address falls inside a single inbound window. For an address that does, it gives the matching local memory address. Software programs two 32-bit registers through a plain word-wide register port. The first is the PCI-side window base. The second holds the local translation base and a size code. The one size code sets the span of both the PCI match window and the local target window.

The translate port is purely combinational: a PCI address goes in, and a hit flag and a local address come out in the same cycle. On a hit, the address bits above the window size come from the translation base and the bits below it pass through unchanged. The translation base can be rewritten while traffic runs, which moves the window to a different part of local memory.

The window base register has fixed low bits that mark the window as prefetchable 32-bit memory space. Its reserved field keeps the window at 4 KB or larger. After reset the window is disabled until software writes a valid size code.

Top module: `inbound_xlate`

## Requirements
- R1: After reset, the base register reads 0x0000_0008, the translation register reads 0x0000_0000, and `win_hit` is low for every PCI address.
- R2: Bits 31:12 of the base register (offset 0x10) are read/write and hold the last value written.
- R3: Bits 11:0 of the base register always read 0x008: bit 3 (prefetchable) is 1, bits 2:1 (address type) are 00, bit 0 (memory space) is 0, and bits 11:4 are 0. Writes to these bits have no effect.
- R4: In the translation register (offset 0x14), bits 31:12 (translation base) and bits 4:0 (size code) are read/write. Bits 11:5 always read zero.
- R5: A read at any offset other than 0x10 or 0x14 returns zero. A write at any other offset changes neither register.
- R6: A size code below 11 disables the window, so `win_hit` stays low and `local_addr` is zero.
- R7: A size code N from 11 to 29 gives a window of 2^(N+1) bytes. `win_hit` is high exactly when PCI address bits 31:N+1 equal the same base register bits.
- R8: A size code of 30 or 31 gives a 2 GB window, and only bit 31 is compared.
- R9: On a hit, `local_addr` is the translation base bits above the window size joined with the PCI address bits below it. On a miss, `local_addr` is zero.
- R10: A base that is not aligned to the window size is masked, so it decodes as the aligned window that contains it.
- R11: A new translation base or size code takes effect on the translate port in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Full-word register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pci_addr | input | 32 | Incoming PCI memory address |
| win_hit | output | 1 | Address falls in the inbound window |
| local_addr | output | 32 | Translated local address, zero on a miss |

## Verification
The translate results and the read data depend combinationally on their inputs, so they are due in the same cycle as the stimulus. Register contents change only at the write clock edge, so they are due one edge after it. The bench drives every input at a falling edge and samples one time unit later, before the next rising edge. Each write is therefore seen exactly one edge after it is presented. The retarget scenario probes the translate port at the first falling edge after the write edge, which confirms the one-cycle latency.

// File: rtl/ibx_pkg.sv
// Package: shared widths and limits for the inbound window translator.
// Assumes a 32-bit PCI address space and a 4 KB minimum window.
package ibx_pkg;
    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int SZ_W     = 5;
    localparam int MIN_SZ   = 11;
    localparam int MAX_SZ   = 30;
    localparam logic [PAGE_LSB-1:0] BASE_RO_BITS = 12'h008;
    typedef logic [ADDR_W-1:0]        addr_t;
    typedef logic [ADDR_W-1:PAGE_LSB] page_t;
    typedef logic [SZ_W-1:0]          size_t;
endpackage

// File: rtl/ibx_regs.sv
// Module: register file holding the window base, translation base and size code.
// Assumes full-word writes only; the read path is combinational.
module ibx_regs
    import ibx_pkg::*;
#(
    parameter int               REG_AW   = 8,
    parameter logic [REG_AW-1:0] BASE_OFF = 8'h10,
    parameter logic [REG_AW-1:0] XLAT_OFF = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  addr_t             wdata,
    output addr_t             rdata,
    output page_t             base_q,
    output page_t             xbase_q,
    output size_t             size_q
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[PAGE_LSB-1:SZ_W];

    // Capture writes to the two defined offsets; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            xbase_q <= '0;
            size_q  <= '0;
        end else if (wr) begin
            if (addr == BASE_OFF) begin
                base_q <= wdata[ADDR_W-1:PAGE_LSB];
            end else if (addr == XLAT_OFF) begin
                xbase_q <= wdata[ADDR_W-1:PAGE_LSB];
                size_q  <= wdata[SZ_W-1:0];
            end
        end
    end

    // Assemble read data with fixed and reserved fields.
    always_comb begin
        rdata = '0;
        if (addr == BASE_OFF) begin
            rdata = {base_q, BASE_RO_BITS};
        end else if (addr == XLAT_OFF) begin
            rdata = {xbase_q, {(PAGE_LSB-SZ_W){1'b0}}, size_q};
        end
    end
endmodule

// File: rtl/ibx_mask.sv
// Module: turns the size code into an upper-bit mask and an enable.
// Assumes codes below MIN_SZ are disabled and codes above MAX_SZ are capped.
module ibx_mask
    import ibx_pkg::*;
(
    input  size_t size,
    output logic  en,
    output addr_t hi_mask
);
    logic [SZ_W:0] eff_n;

    // Clamp the size code at the 2 GB limit.
    always_comb begin
        eff_n = (size > size_t'(MAX_SZ)) ? (SZ_W+1)'(MAX_SZ) : {1'b0, size};
        en    = (size >= size_t'(MIN_SZ));
    end

    // One mask bit per address bit: set above the window size.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign hi_mask[i] = ((SZ_W+1)'(i) > eff_n);
    end
endmodule

// File: rtl/ibx_match.sv
// Module: compares the PCI address with the window and forms the local address.
// Assumes hi_mask has no bits set below PAGE_LSB whenever en is high.
module ibx_match
    import ibx_pkg::*;
(
    input  logic  en,
    input  addr_t hi_mask,
    input  addr_t pci,
    input  page_t base,
    input  page_t xbase,
    output logic  hit,
    output addr_t local_a
);
    addr_t base_full;
    addr_t xbase_full;

    // Decode the hit and splice the translated upper bits onto the offset.
    always_comb begin
        base_full  = {base,  {PAGE_LSB{1'b0}}};
        xbase_full = {xbase, {PAGE_LSB{1'b0}}};
        hit        = en && ((pci & hi_mask) == (base_full & hi_mask));
        local_a    = hit ? ((xbase_full & hi_mask) | (pci & ~hi_mask)) : '0;
    end
endmodule

// File: rtl/inbound_xlate.sv
// Module: top of the inbound PCI window translator.
// Assumes a synchronous active-low reset and one window.
module inbound_xlate
    import ibx_pkg::*;
#(
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] BASE_OFF = 8'h10,
    parameter logic [REG_AW-1:0] XLAT_OFF = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       pci_addr,
    output logic              win_hit,
    output logic [31:0]       local_addr
);
    page_t base_q;
    page_t xbase_q;
    size_t size_q;
    logic  win_en;
    addr_t hi_mask;

    ibx_regs #(.REG_AW(REG_AW), .BASE_OFF(BASE_OFF), .XLAT_OFF(XLAT_OFF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .base_q(base_q), .xbase_q(xbase_q), .size_q(size_q)
    );

    ibx_mask u_mask (.size(size_q), .en(win_en), .hi_mask(hi_mask));

    ibx_match u_match (
        .en(win_en), .hi_mask(hi_mask), .pci(pci_addr),
        .base(base_q), .xbase(xbase_q),
        .hit(win_hit), .local_a(local_addr)
    );
endmodule

// File: rtl/ibx_checker.sv
// Module: assertion checker for the inbound translator, bound to the top.
// Assumes the register offsets are passed in from the bound instance.
module ibx_checker #(
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] BASE_OFF = 8'h10,
    parameter logic [REG_AW-1:0] XLAT_OFF = 8'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [31:0]       pci_addr,
    input logic              win_hit,
    input logic [31:0]       local_addr,
    input logic [4:0]        size_q
);
    a_r2_base_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == BASE_OFF) |=>
        (reg_addr != BASE_OFF || reg_rdata[31:12] == $past(reg_wdata[31:12])));

    a_r3_fixed_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == BASE_OFF) |-> (reg_rdata[11:0] == 12'h008));

    a_r4_xlate_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == XLAT_OFF) |-> (reg_rdata[11:5] == 7'h0));

    a_r5_other_offsets_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != BASE_OFF && reg_addr != XLAT_OFF) |-> (reg_rdata == 32'h0));

    a_r6_hit_needs_size: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (size_q >= 5'd11));

    a_r9_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (local_addr == 32'h0));

    a_r9_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (local_addr[11:0] == pci_addr[11:0]));
endmodule

bind inbound_xlate ibx_checker #(.REG_AW(REG_AW), .BASE_OFF(BASE_OFF), .XLAT_OFF(XLAT_OFF)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_addr(pci_addr),
    .win_hit(win_hit), .local_addr(local_addr), .size_q(size_q)
);

// File: tb/inbound_xlate_bench.sv
module inbound_xlate_bench;
    localparam logic [7:0] OFF_B = 8'h10;
    localparam logic [7:0] OFF_X = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] pci_addr = 32'h0;
    logic        win_hit;
    logic [31:0] local_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    inbound_xlate u_inbound_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pci_addr(pci_addr),
        .win_hit(win_hit), .local_addr(local_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Independent reference: window of 2^(n+1) bytes, capped at 2^31.
    function automatic logic [32:0] model(input logic [31:0] pci, input logic [31:0] base,
                                          input logic [31:0] xb, input int n);
        int w;
        logic h;
        logic [31:0] lo;
        if (n < 11) return 33'h0;
        w  = (n >= 30) ? 31 : n + 1;
        h  = ((pci >> w) == (base >> w));
        lo = pci & ((32'h1 << w) - 32'h1);
        return {h, h ? (((xb >> w) << w) | lo) : 32'h0};
    endfunction

    task automatic probe(input string tag, input logic [31:0] pci, input logic [32:0] exp);
        @(negedge clk);
        pci_addr = pci;
        #1;
        chk({tag, " hit"}, {31'h0, win_hit}, {31'h0, exp[32]});
        chk({tag, " local"}, local_addr, exp[31:0]);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(OFF_B, d); chk("R1 base reset", d, 32'h0000_0008);
        rd(OFF_X, d); chk("R1 xlate reset", d, 32'h0);
        probe("R1 no hit at 0", 32'h0, 33'h0);
        probe("R1 no hit at top", 32'hFFFF_FFFF, 33'h0);
    endtask

    task automatic t_base_rw();
        logic [31:0] d;
        wr(OFF_B, 32'hFFFF_FFFF); rd(OFF_B, d);
        chk("R2 R3 base all ones", d, 32'hFFFF_F008);
        wr(OFF_B, 32'hA5A5_0FF7); rd(OFF_B, d);
        chk("R2 R3 base pattern", d, 32'hA5A5_0008);
        wr(OFF_B, 32'h0); rd(OFF_B, d);
        chk("R3 base zero", d, 32'h0000_0008);
    endtask

    task automatic t_xlate_rw();
        logic [31:0] d;
        wr(OFF_X, 32'hFFFF_FFFF); rd(OFF_X, d);
        chk("R4 xlate all ones", d, 32'hFFFF_F01F);
        wr(OFF_X, 32'h1234_5FEA); rd(OFF_X, d);
        chk("R4 xlate pattern", d, 32'h1234_500A);
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        wr(OFF_B, 32'h4000_0000);
        wr(OFF_X, 32'h8000_000C);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R5 offset 00", d, 32'h0);
        rd(8'h18, d); chk("R5 offset 18", d, 32'h0);
        rd(8'hFC, d); chk("R5 offset FC", d, 32'h0);
        rd(OFF_B, d); chk("R5 base untouched", d, 32'h4000_0008);
        rd(OFF_X, d); chk("R5 xlate untouched", d, 32'h8000_000C);
    endtask

    task automatic t_disabled();
        wr(OFF_B, 32'h0);
        wr(OFF_X, 32'h8000_000A);
        probe("R6 size 10", 32'h0000_0100, 33'h0);
        wr(OFF_X, 32'h8000_0000);
        probe("R6 size 0", 32'h0000_0000, 33'h0);
    endtask

    task automatic t_sizes();
        int ns [4] = '{11, 15, 20, 29};
        foreach (ns[k]) begin
            int n = ns[k];
            logic [31:0] base = 32'h4000_0000;
            logic [31:0] xb   = 32'h9ABC_D000;
            logic [31:0] span = 32'h1 << (n + 1);
            wr(OFF_B, base);
            wr(OFF_X, xb | 32'(n));
            probe("R7 R9 first byte", base, model(base, base, xb, n));
            probe("R7 R9 last byte", base + span - 1, model(base + span - 1, base, xb, n));
            probe("R7 past end", base + span, model(base + span, base, xb, n));
            probe("R7 below base", base - 1, model(base - 1, base, xb, n));
            probe("R9 mid offset", base + (span >> 1) + 32'h123, model(base + (span >> 1) + 32'h123, base, xb, n));
        end
    endtask

    task automatic t_two_gig();
        for (int n = 30; n <= 31; n++) begin
            wr(OFF_B, 32'h8000_0000);
            wr(OFF_X, 32'h0000_0000 | 32'(n));
            probe("R8 top hit", 32'hFFFF_FFFF, {1'b1, 32'h7FFF_FFFF});
            probe("R8 low half miss", 32'h7FFF_FFFF, 33'h0);
            probe("R8 base hit", 32'h8000_0000, {1'b1, 32'h0000_0000});
        end
    endtask

    task automatic t_unaligned();
        wr(OFF_B, 32'h1234_5000);
        wr(OFF_X, 32'h0050_000F);
        probe("R10 aligned start", 32'h1234_0004, {1'b1, 32'h0050_0004});
        probe("R10 last byte", 32'h1234_FFFF, {1'b1, 32'h0050_FFFF});
        probe("R10 next window", 32'h1235_0000, 33'h0);
    endtask

    task automatic t_retarget();
        wr(OFF_B, 32'h2000_0000);
        wr(OFF_X, 32'h0100_000B);
        pci_addr = 32'h2000_0ABC;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = OFF_X; reg_wdata = 32'h0700_000B;
        #1 chk("R11 old target before edge", local_addr, 32'h0100_0ABC);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R11 new target after edge", local_addr, 32'h0700_0ABC);
        chk("R11 still hit", {31'h0, win_hit}, 32'h1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base_rw();
        t_xlate_rw();
        t_offsets();
        t_disabled();
        t_sizes();
        t_two_gig();
        t_unaligned();
        t_retarget();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule